// File: doc/BRIEF.md
# Nibble-Serial Flow-Control Frame Receiver

This block takes in flow-control frames that arrive four bits at a time on a narrow lane. The lane also carries a start-of-frame strobe and one parity bit for each nibble. The block rebuilds 16-bit words from the nibbles and checks two kinds of parity: parity on every nibble, and a check word that closes the frame. It then places each good, non-idle frame into an ingress FIFO, where a local consumer reads it one word at a time.

Words go into the FIFO as they arrive, but the consumer cannot see them yet. A frame becomes readable only when its check word proves good. If the frame fails, the write pointer falls back to where that frame began, so nothing of it remains. Idle frames keep the link busy when there is no traffic, and they are never stored. A registered full-level output tells the far-end transmitter to hold off whenever the number of stored words reaches a threshold set on an input.

Top module: `frm_rx`

## Requirements
- R1: After the strobe, every four nibbles make one 16-bit word, first nibble in bits 15:12. The nibble that comes with the strobe starts a new frame and is the top nibble of its header word.
- R2: The parity bit is correct when the nibble plus the parity bit holds an odd number of ones. A frame with a wrong parity bit on any of its nibbles is dropped entirely.
- R3: The last word of a frame is its check word. The frame is kept only if the XOR of all its words, check word included, is zero. Otherwise it is dropped entirely.
- R4: In the header, bits 15:12 give the frame kind and bits 3:0 give N, the number of payload words. A frame is the header, then N payload words, then the check word. A kept frame stores the header and the payload words in arrival order, and never the check word.
- R5: A frame of kind 0 is an idle frame. It never adds a word to the FIFO.
- R6: The reader cannot see any word of a frame until the check word has been accepted. Reading during a frame returns no data if the FIFO was empty before that frame.
- R7: A strobe in the middle of a frame drops the partial frame and starts a new frame with that nibble.
- R8: When no frame is open, cycles with the strobe low are ignored, whatever the nibble and parity lines carry.
- R9: A frame whose header and payload do not fit in the free space is dropped entirely. Frames stored earlier are not affected.
- R10: The backpressure output is high exactly while the stored word count is at or above the threshold input. A change to the threshold shows one cycle later.
- R11: A read request while words are stored gives the oldest word, with the valid flag, on the next cycle. A read request while the FIFO is empty gives no valid flag and changes nothing.
- R12: After reset the FIFO is empty, the valid flag is low and no frame is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_nib | input | 4 | Received nibble |
| rx_sof | input | 1 | Start-of-frame strobe, high with the first nibble |
| rx_par | input | 1 | Odd parity bit for rx_nib |
| hwm | input | AW+1 | Threshold in words for backpressure |
| rd_en | input | 1 | Read request |
| rd_data | output | 16 | Word read out |
| rd_valid | output | 1 | rd_data holds a word this cycle |
| bp | output | 1 | Backpressure to the far-end transmitter |

## Verification
The bench builds the block with AW=3, so the FIFO holds 8 words. At that size every fitting frame length from 0 to 7 payload words can be swept, up to the frame that exactly fills the FIFO. Overflow cases are easy to reach, as are frames that can never fit. Every threshold from 0 to 8 can be walked against every fill level. With the small frames the bench can also corrupt each nibble position in turn, and cut a frame short at each position, with a strobe at every point.

// File: rtl/frm_rx_pkg.sv
package frm_rx_pkg;
  // Controller view of where the current word sits in a frame
  typedef enum logic [1:0] {
    WP_HEAD,
    WP_BODY,
    WP_CHECK
  } word_pos_t;

  function automatic logic nib_par_bad(input logic [3:0] nib, input logic par);
    // odd parity over nibble plus parity bit is the correct case
    return ~(^{nib, par});
  endfunction
endpackage

// File: rtl/frm_nib_asm.sv
module frm_nib_asm #(
  parameter int NIB_W  = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NIB_W-1:0]  nib,
  input  logic              sof,
  input  logic              par,
  input  logic              open,
  output logic              wd_vld,
  output logic [WORD_W-1:0] wd_data,
  output logic              wd_perr,
  output logic              wd_first
);
  import frm_rx_pkg::*;

  localparam int NIBS = WORD_W / NIB_W;
  localparam int CW   = $clog2(NIBS);
  localparam int SH_W = WORD_W - NIB_W;

  logic [SH_W-1:0] sh_q;
  logic [CW-1:0]   cnt_q;
  logic            perr_q;
  logic            first_q;

  logic [CW-1:0] idx;
  logic          take;
  logic          bad_now;
  logic          perr_eff;

  assign take     = sof | open;
  assign idx      = sof ? '0 : cnt_q;
  assign bad_now  = nib_par_bad(nib, par);
  assign perr_eff = (sof ? 1'b0 : perr_q) | bad_now;

  // word is handed over combinationally with its last nibble
  assign wd_vld   = take && (idx == CW'(NIBS - 1));
  assign wd_data  = {sh_q, nib};
  assign wd_perr  = perr_eff;
  assign wd_first = sof | first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      perr_q  <= 1'b0;
      first_q <= 1'b0;
    end else if (take) begin
      sh_q <= SH_W'({sh_q, nib});
      if (idx == CW'(NIBS - 1)) begin
        cnt_q   <= '0;
        perr_q  <= 1'b0;
        first_q <= 1'b0;
      end else begin
        cnt_q   <= idx + CW'(1);
        perr_q  <= perr_eff;
        first_q <= sof | first_q;
      end
    end
  end
endmodule

// File: rtl/frm_ctrl.sv
module frm_ctrl #(
  parameter int WORD_W = 16,
  parameter int LEN_W  = 4,
  parameter int KIND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              wd_vld,
  input  logic [WORD_W-1:0] wd_data,
  input  logic              wd_perr,
  input  logic              wd_first,
  input  logic              spec_full,
  output logic              open,
  output logic              wr_en,
  output logic              commit,
  output logic              rewind
);
  import frm_rx_pkg::*;

  localparam int LW = LEN_W + 1;

  logic              open_q;
  logic [LW-1:0]     left_q;
  logic [WORD_W-1:0] vp_q;
  logic              bad_q;
  logic              idle_q;

  word_pos_t         pos;
  logic              hdr_idle;
  logic [WORD_W-1:0] vp_end;
  logic [LEN_W-1:0]  hdr_len;

  assign open     = open_q;
  assign hdr_idle = (wd_data[WORD_W-1 -: KIND_W] == '0);
  assign hdr_len  = wd_data[LEN_W-1:0];
  assign vp_end   = vp_q ^ wd_data;

  always_comb begin
    if (wd_first)                pos = WP_HEAD;
    else if (left_q > LW'(1))    pos = WP_BODY;
    else                         pos = WP_CHECK;
  end

  always_comb begin
    wr_en  = 1'b0;
    commit = 1'b0;
    rewind = 1'b0;
    if (sof && open_q) rewind = 1'b1;
    if (wd_vld) begin
      case (pos)
        WP_HEAD: wr_en = !hdr_idle && !spec_full;
        WP_BODY: wr_en = !idle_q && !spec_full;
        default: begin
          commit = !idle_q && !bad_q && !wd_perr && (vp_end == '0);
          rewind = !commit;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      left_q <= '0;
      vp_q   <= '0;
      bad_q  <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      if (sof) open_q <= 1'b1;
      if (wd_vld) begin
        case (pos)
          WP_HEAD: begin
            left_q <= {1'b0, hdr_len} + LW'(1);
            vp_q   <= wd_data;
            bad_q  <= wd_perr | (spec_full & ~hdr_idle);
            idle_q <= hdr_idle;
          end
          WP_BODY: begin
            left_q <= left_q - LW'(1);
            vp_q   <= vp_end;
            bad_q  <= bad_q | wd_perr | (spec_full & ~idle_q);
          end
          default: open_q <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/frm_fifo.sv
module frm_fifo #(
  parameter int AW     = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              commit,
  input  logic              rewind,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              spec_full,
  output logic [AW:0]       lvl,
  output logic [AW:0]       spec_lvl,
  output logic [AW:0]       lvl_nxt
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW:0] wps_q, wpc_q, rp_q;
  logic [AW:0] wps_n, wpc_n, rp_n;
  logic        rd_ok;

  assign lvl       = wpc_q - rp_q;
  assign spec_lvl  = wps_q - rp_q;
  assign spec_full = (spec_lvl == (AW+1)'(DEPTH));
  assign rd_ok     = rd_en && (lvl != '0);

  always_comb begin
    wps_n = wps_q;
    if (rewind)     wps_n = wpc_q;
    else if (wr_en) wps_n = wps_q + (AW+1)'(1);
    wpc_n = commit ? wps_q : wpc_q;
    rp_n  = rd_ok ? rp_q + (AW+1)'(1) : rp_q;
  end

  assign lvl_nxt = wpc_n - rp_n;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wps_q[AW-1:0]] <= wr_data;
    if (rd_ok) rd_data <= mem[rp_q[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wps_q    <= '0;
      wpc_q    <= '0;
      rp_q     <= '0;
      rd_valid <= 1'b0;
    end else begin
      wps_q    <= wps_n;
      wpc_q    <= wpc_n;
      rp_q     <= rp_n;
      rd_valid <= rd_ok;
    end
  end
endmodule

// File: rtl/frm_hwm.sv
module frm_hwm #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [AW:0] lvl_nxt,
  input  logic [AW:0] hwm,
  output logic        bp
);
  always_ff @(posedge clk) begin
    if (rst) bp <= (hwm == '0);
    else     bp <= (lvl_nxt >= hwm);
  end
endmodule

// File: rtl/frm_rx.sv
module frm_rx #(
  parameter int AW     = 4,
  parameter int NIB_W  = 4,
  parameter int WORD_W = 16,
  parameter int LEN_W  = 4,
  parameter int KIND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NIB_W-1:0]  rx_nib,
  input  logic              rx_sof,
  input  logic              rx_par,
  input  logic [AW:0]       hwm,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              bp
);
  logic              wd_vld, wd_perr, wd_first;
  logic [WORD_W-1:0] wd_data;
  logic              fr_busy, fr_wr, fr_commit, fr_rewind;
  logic              spec_full;
  logic [AW:0]       fill_lvl, spec_lvl, lvl_nxt;

  frm_nib_asm #(.NIB_W(NIB_W), .WORD_W(WORD_W)) u_asm (
    .clk(clk), .rst(rst), .nib(rx_nib), .sof(rx_sof), .par(rx_par),
    .open(fr_busy), .wd_vld(wd_vld), .wd_data(wd_data),
    .wd_perr(wd_perr), .wd_first(wd_first)
  );

  frm_ctrl #(.WORD_W(WORD_W), .LEN_W(LEN_W), .KIND_W(KIND_W)) u_ctrl (
    .clk(clk), .rst(rst), .sof(rx_sof), .wd_vld(wd_vld), .wd_data(wd_data),
    .wd_perr(wd_perr), .wd_first(wd_first), .spec_full(spec_full),
    .open(fr_busy), .wr_en(fr_wr), .commit(fr_commit), .rewind(fr_rewind)
  );

  frm_fifo #(.AW(AW), .WORD_W(WORD_W)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(fr_wr), .wr_data(wd_data),
    .commit(fr_commit), .rewind(fr_rewind), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .spec_full(spec_full),
    .lvl(fill_lvl), .spec_lvl(spec_lvl), .lvl_nxt(lvl_nxt)
  );

  frm_hwm #(.AW(AW)) u_hwm (
    .clk(clk), .rst(rst), .lvl_nxt(lvl_nxt), .hwm(hwm), .bp(bp)
  );
endmodule

// File: rtl/frm_rx_chk.sv
module frm_rx_chk #(
  parameter int AW = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        rx_sof,
  input logic        rd_en,
  input logic        rd_valid,
  input logic        bp,
  input logic [AW:0] hwm,
  input logic [AW:0] lvl,
  input logic [AW:0] spec_lvl,
  input logic        busy,
  input logic        commit
);
  localparam int DEPTH = 1 << AW;

  AST_BP_MATCH: assert property (@(posedge clk) disable iff (rst)
    bp == (lvl >= $past(hwm))); // R10

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && lvl == '0) |=> !rd_valid); // R11

  AST_LVL_MAX: assert property (@(posedge clk) disable iff (rst)
    (lvl <= (AW+1)'(DEPTH)) && (spec_lvl <= (AW+1)'(DEPTH))); // R9

  AST_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
    !commit |=> lvl <= $past(lvl)); // R6

  AST_ABORT: assert property (@(posedge clk) disable iff (rst)
    (rx_sof && busy) |=> spec_lvl == lvl); // R7

  AST_DEAD: assert property (@(posedge clk) disable iff (rst)
    (!rx_sof && !busy) |=> !busy); // R8

  AST_RST_STATE: assert property (@(posedge clk)
    rst |=> (!rd_valid && lvl == '0 && !busy)); // R12
endmodule

bind frm_rx frm_rx_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rx_sof(rx_sof), .rd_en(rd_en), .rd_valid(rd_valid),
  .bp(bp), .hwm(hwm), .lvl(fill_lvl), .spec_lvl(spec_lvl),
  .busy(fr_busy), .commit(fr_commit)
);

// File: tb/frm_rx_test.sv
`timescale 1ns/1ps
module frm_rx_test;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  nib = '0;
  logic        sof = 1'b0;
  logic        par = 1'b0;
  logic [AW:0] hwm = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        bp;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [15:0] mq[$];

  always #2.5 clk = ~clk;

  frm_rx #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .rx_nib(nib), .rx_sof(sof), .rx_par(par),
    .hwm(hwm), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .bp(bp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic dead(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sof   = 1'b0;
      rd_en = 1'b0;
      nib   = 4'(k * 7 + 3);
      par   = 1'(k);
    end
  endtask

  task automatic send(input int kind, input int len, input int seed, input int bad_nib,
                      input bit bad_vp, input int trunc, input int probe);
    logic [15:0] w [0:17];
    logic [15:0] vp;
    int lim;
    bit pend;
    w[0] = {4'(kind), 8'(seed), 4'(len)};
    vp = w[0];
    for (int i = 1; i <= len; i++) begin
      w[i] = 16'(seed * 40503 + i * 4093 + 17);
      vp ^= w[i];
    end
    w[len+1] = bad_vp ? (vp ^ 16'h0100) : vp;
    lim  = (trunc > 0) ? trunc : (len + 2) * 4;
    pend = 0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (pend) begin
        chk(rd_valid == 1'b0, "R6 read during frame", rd_valid, 0);
        pend = 0;
      end
      nib   = w[k/4][15 - 4*(k%4) -: 4];
      sof   = (k == 0);
      par   = (~^nib) ^ (k == bad_nib);
      rd_en = (k == probe);
      if (k == probe) pend = 1;
    end
    if (trunc == 0 && bad_nib < 0 && !bad_vp && kind != 0 &&
        mq.size() + len + 1 <= DEPTH)
      for (int i = 0; i <= len; i++) mq.push_back(w[i]);
  endtask

  task automatic chk_bp(input string req);
    chk(bp == (mq.size() >= int'(hwm)), req, bp, (mq.size() >= int'(hwm)));
  endtask

  task automatic drain();
    logic [15:0] e;
    while (mq.size() > 0) begin
      e = mq.pop_front();
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      chk(rd_valid && rd_data == e, "R1 R4 R11 word order and value", rd_data, e);
      chk_bp("R10 bp after read");
    end
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk(!rd_valid, "R11 R5 read when empty", rd_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    hwm = 4'd5;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk(!rd_valid, "R12 valid after reset", rd_valid, 0);
    chk(!bp, "R12 bp after reset", bp, 0);
    drain();

    // R8: long dead run carries garbage only
    dead(40);
    drain();

    // R1 R4: sweep kinds and every fitting length
    hwm = 4'd8;
    foreach (mq[i]) ;
    for (int kd = 1; kd < 16; kd += 7) begin
      for (int ln = 0; ln < DEPTH; ln++) begin
        send(kd, ln, kd * 16 + ln, -1, 0, 0, -1);
        dead(2);
        chk_bp("R10 bp after frame");
        drain();
      end
    end

    // R5: idle frames store nothing
    for (int ln = 0; ln < 4; ln++) begin
      send(0, ln, 50 + ln, -1, 0, 0, -1);
      dead(1);
    end
    drain();

    // R2: nibble parity error at each position drops the frame
    for (int b = 0; b < 16; b++) begin
      send(6, 2, 90 + b, b, 0, 0, -1);
      dead(1);
      send(3, 1, 120 + b, -1, 0, 0, -1);
      dead(1);
      drain();
    end

    // R3: bad check word drops the frame
    for (int ln = 0; ln < 4; ln++) begin
      send(9, ln, 140 + ln, -1, 1, 0, -1);
      dead(3);
      send(2, ln, 150 + ln, -1, 0, 0, -1);
      dead(1);
      drain();
    end

    // R7: strobe in mid-frame restarts assembly
    for (int t = 1; t < 16; t++) begin
      send(7, 2, 160 + t, -1, 0, t, -1);
      send(4, 1, 180 + t, -1, 0, 0, -1);
      dead(1);
      drain();
    end

    // R6: reader sees nothing while a frame is in flight
    send(5, 3, 200, -1, 0, 0, 8);
    dead(1);
    drain();

    // R9: overflow drops only the frame that does not fit
    send(1, 4, 210, -1, 0, 0, -1); dead(1);
    send(1, 3, 211, -1, 0, 0, -1); dead(1);
    send(1, 2, 212, -1, 0, 0, -1); dead(1);
    chk_bp("R9 R10 bp at full");
    drain();
    send(1, 15, 213, -1, 0, 0, -1); dead(1);
    send(2, 0, 214, -1, 0, 0, -1); dead(1);
    drain();

    // R10: every threshold against every fill level
    for (int h = 0; h <= DEPTH; h++) begin
      @(negedge clk); hwm = (AW+1)'(h);
      dead(2);
      chk_bp("R10 bp empty");
      for (int f = 0; f < DEPTH; f++) begin
        send(8, 0, 230 + f, -1, 0, 0, -1);
        dead(1);
        chk_bp("R10 bp filling");
      end
      send(8, 0, 250, -1, 0, 0, -1);
      dead(1);
      chk_bp("R9 R10 bp full, extra frame dropped");
      drain();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule